// File: doc/BRIEF.md
# Flash Embedded Operation Status Generator

This block models what a parallel flash device returns on its data pins while an internal program or erase is running. A command decoder in front of it turns bus write sequences into single-cycle start and command pulses. The block keeps a small byte array split into equal sectors, times each operation with counters, and answers every read with either array data or a status byte. A host polls that byte to learn whether the operation is still running, has finished or has failed.

Sector erases can be suspended. While suspended, the array outside the erased sector can be read and programmed, and the erase can later be resumed. Protected sectors are never changed: an operation aimed only at them runs a short dummy interval and then returns to array reads. A program that tries to turn a stored 0 into a 1 never finishes. It runs into a time limit, and the failure is latched until a reset command. Each duration is a parameter, so simulations can use short intervals.

Top module: `flash_op_status`

## Requirements
- R1: After reset every array byte reads FFh and `rd_data` is 00h. `rd_data` is updated on the clock edge where `rd_stb` is high and holds its value in every other cycle.
- R2: A program to an unprotected byte takes effect as the stored byte AND the new data. Until it completes, a read at any address returns bit 7 equal to the inverse of bit 7 of the written data.
- R3: During a running program or erase, bit 6 of the read data inverts on every read at any address. When the operation ends, reads return array data again.
- R4: The status byte places the data-poll flag in bit 7, the toggle flag in bit 6, the failure flag in bit 5, the erase-started flag in bit 3 and the sector toggle flag in bit 2. Bits 4, 1 and 0 are zero. The erase-started flag is 1 during erase and suspend and 0 during program.
- R5: A program that would turn a stored 0 into a 1 runs `T_LIMIT` cycles and then sets bit 5. Bit 5 then stays set and bit 6 keeps toggling until `op_reset` is pulsed. After the reset, the byte reads unchanged.
- R6: A sector erase reads bit 7 as 0 while it runs. When it completes, every byte of that sector reads FFh and other sectors are unchanged.
- R7: A chip erase sets every byte of every unprotected sector to FFh. Protected sectors keep their contents.
- R8: While an erase is running or suspended, bit 2 inverts only on reads inside the sectors being erased. It stays steady on reads elsewhere.
- R9: `op_suspend` is honoured only during a sector erase and takes effect after `T_SUSP` cycles. Once suspended, reads in the erased sector return bit 7 = 1, a steady bit 6 and a toggling bit 2, and reads in other sectors return array data. Suspend during a chip erase is ignored.
- R10: While suspended, a program to another sector behaves as a normal program and then returns to the suspended state. A program aimed at the suspended sector is ignored.
- R11: `op_resume` in the suspended state continues the erase where it stopped, and the erase then runs to completion.
- R12: A program to a protected sector runs `T_PPROT` cycles of status and leaves the data unchanged. An erase whose selected sectors are all protected runs `T_EPROT` cycles of status and leaves the data unchanged.
- R13: While an operation is running, `op_reset` and any start pulse have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_prog | input | 1 | Start a program of `wr_data` at `wr_addr` |
| op_serase | input | 1 | Start an erase of the sector holding `wr_addr` |
| op_cerase | input | 1 | Start a chip erase |
| op_suspend | input | 1 | Suspend the running sector erase |
| op_resume | input | 1 | Resume the suspended erase |
| op_reset | input | 1 | Clear a latched failure |
| wr_addr | input | AW | Program or erase target address |
| wr_data | input | 8 | Program data |
| sect_lock | input | N_SECT | Per-sector protection, 1 = protected |
| rd_stb | input | 1 | Read request, one cycle per read |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Read result, valid the cycle after `rd_stb` |

## Verification
Several properties are checked on every cycle: the read register holds between strobes, bit 7 reads 0 during an erase, the toggle source stays frozen during suspend, a failure stays latched until reset, a chip erase never enters suspend, resume always re-enters the erase, and the array never sees two writers at once. The remaining behaviour can only be shown by the bench scenarios, because it depends on sequences and stored contents. This covers the AND rule of programming, the 0-to-1 failure, which sectors an erase clears, the bit 2 pattern inside and outside the erased sector, the program-during-suspend round trip and the protected-sector dummy runs.

// File: rtl/eos_pkg.sv
package eos_pkg;
   typedef enum logic [2:0] {
      M_IDLE,   // array reads
      M_PROG,   // program running
      M_PPROT,  // dummy program on a protected sector
      M_FAIL,   // program exceeded its limit
      M_ERASE,  // erase running
      M_EPROT,  // dummy erase, all targets protected
      M_SPEND,  // suspend requested, erase still running
      M_SUSP    // erase suspended
   } eos_mode_e;
endpackage

// File: rtl/eos_array.sv
module eos_array #(
   parameter int N_SECT  = 8,
   parameter int SECT_AW = 2,
   parameter int AW      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic [AW-1:0]     prog_addr,
   input  logic [7:0]        prog_data,
   input  logic              erase_we,
   input  logic [N_SECT-1:0] erase_mask,
   input  logic [AW-1:0]     rd_addr,
   output logic [7:0]        rd_byte,
   input  logic [AW-1:0]     chk_addr,
   output logic [7:0]        chk_byte
);
   localparam int BPS   = 1 << SECT_AW;
   localparam int DEPTH = N_SECT * BPS;
   localparam int SW    = AW - SECT_AW;

   logic [DEPTH-1:0][7:0] flat;

   for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      localparam logic [SW-1:0] SID = SW'(s);
      logic [BPS-1:0][7:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= {BPS{8'hFF}};
         else if (erase_we && erase_mask[s])
            cell_q <= {BPS{8'hFF}};
         else if (prog_we && prog_addr[AW-1:SECT_AW] == SID)
            cell_q[prog_addr[SECT_AW-1:0]] <= cell_q[prog_addr[SECT_AW-1:0]] & prog_data;
      end
      for (genvar b = 0; b < BPS; b++) begin : g_byte
         assign flat[s*BPS + b] = cell_q[b];
      end
   end

   assign rd_byte  = flat[rd_addr];
   assign chk_byte = flat[chk_addr];

   // R13: the sequencer never programs and erases in the same cycle
   a_r13_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_we && erase_we));
endmodule

// File: rtl/eos_seq.sv
module eos_seq
   import eos_pkg::*;
#(
   parameter int N_SECT  = 8,
   parameter int SECT_AW = 2,
   parameter int AW      = 5,
   parameter int T_PROG  = 8,
   parameter int T_LIMIT = 40,
   parameter int T_ERASE = 64,
   parameter int T_SUSP  = 4,
   parameter int T_PPROT = 6,
   parameter int T_EPROT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_prog,
   input  logic              op_serase,
   input  logic              op_cerase,
   input  logic              op_suspend,
   input  logic              op_resume,
   input  logic              op_reset,
   input  logic [AW-1:0]     wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [N_SECT-1:0] sect_lock,
   input  logic [7:0]        cur_byte,
   output eos_mode_e         mode,
   output logic [N_SECT-1:0] emask,
   output logic              pbit7,
   output logic              prog_we,
   output logic [AW-1:0]     prog_addr,
   output logic [7:0]        prog_data,
   output logic              erase_we,
   output logic [N_SECT-1:0] erase_mask
);
   localparam int CW = $clog2(T_PROG + T_LIMIT + T_SUSP + T_PPROT + T_EPROT + 1);
   localparam int EW = $clog2(T_ERASE + 1);
   localparam int SW = AW - SECT_AW;

   eos_mode_e         mode_q;
   logic [CW-1:0]     cnt_q;
   logic [EW-1:0]     ecnt_q;
   logic [N_SECT-1:0] emask_q;
   logic [AW-1:0]     paddr_q;
   logic [7:0]        pdata_q;
   logic              doom_q, chip_q, ret_susp_q;

   logic [SW-1:0]     wsec;
   logic [N_SECT-1:0] new_mask;
   logic              launch_prog, raise;
   eos_mode_e         home;

   always_comb begin
      wsec        = wr_addr[AW-1:SECT_AW];
      new_mask    = (op_serase ? (N_SECT'(1) << wsec) : {N_SECT{1'b1}}) & ~sect_lock;
      raise       = |(wr_data & ~cur_byte);
      launch_prog = op_prog && (mode_q == M_IDLE || (mode_q == M_SUSP && !emask_q[wsec]));
      home        = ret_susp_q ? M_SUSP : M_IDLE;
      prog_we     = (mode_q == M_PROG) && !doom_q && cnt_q == CW'(T_PROG - 1);
      erase_we    = (mode_q == M_ERASE || mode_q == M_SPEND) && ecnt_q == EW'(T_ERASE - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= M_IDLE;
         cnt_q      <= '0;
         ecnt_q     <= '0;
         emask_q    <= '0;
         paddr_q    <= '0;
         pdata_q    <= '0;
         doom_q     <= 1'b0;
         chip_q     <= 1'b0;
         ret_susp_q <= 1'b0;
      end else begin
         if (launch_prog && !(mode_q == M_SUSP && op_resume)) begin
            paddr_q    <= wr_addr;
            pdata_q    <= wr_data;
            doom_q     <= raise;
            cnt_q      <= '0;
            ret_susp_q <= (mode_q == M_SUSP);
            mode_q     <= sect_lock[wsec] ? M_PPROT : M_PROG;
         end else begin
            case (mode_q)
               M_IDLE: if (op_serase || op_cerase) begin
                  emask_q <= new_mask;
                  chip_q  <= !op_serase;
                  ecnt_q  <= '0;
                  cnt_q   <= '0;
                  mode_q  <= (new_mask == '0) ? M_EPROT : M_ERASE;
               end
               M_PROG: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (doom_q && cnt_q == CW'(T_LIMIT - 1)) mode_q <= M_FAIL;
                  else if (prog_we)                        mode_q <= home;
               end
               M_PPROT: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CW'(T_PPROT - 1)) mode_q <= home;
               end
               M_FAIL: if (op_reset) mode_q <= home;
               M_ERASE: begin
                  ecnt_q <= ecnt_q + 1'b1;
                  if (erase_we) begin
                     mode_q  <= M_IDLE;
                     emask_q <= '0;
                  end else if (op_suspend && !chip_q) begin
                     cnt_q  <= '0;
                     mode_q <= M_SPEND;
                  end
               end
               M_SPEND: begin
                  ecnt_q <= ecnt_q + 1'b1;
                  cnt_q  <= cnt_q + 1'b1;
                  if (erase_we) begin
                     mode_q  <= M_IDLE;
                     emask_q <= '0;
                  end else if (cnt_q == CW'(T_SUSP - 1)) mode_q <= M_SUSP;
               end
               M_EPROT: begin
                  cnt_q <= cnt_q + 1'b1;
                  if (cnt_q == CW'(T_EPROT - 1)) mode_q <= M_IDLE;
               end
               M_SUSP: if (op_resume) begin
                  ret_susp_q <= 1'b0;
                  mode_q     <= M_ERASE;
               end
               default: mode_q <= M_IDLE;
            endcase
         end
      end
   end

   assign mode       = mode_q;
   assign emask      = emask_q;
   assign pbit7      = pdata_q[7];
   assign prog_addr  = paddr_q;
   assign prog_data  = pdata_q;
   assign erase_mask = emask_q;

   a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_FAIL && !op_reset) |=> mode_q == M_FAIL);
   a_r9_chip_no_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_ERASE && chip_q) |=> mode_q != M_SPEND);
   a_r11_resume_erases: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_SUSP && op_resume) |=> mode_q == M_ERASE);
endmodule

// File: rtl/eos_fmt.sv
module eos_fmt
   import eos_pkg::*;
#(
   parameter int N_SECT = 8,
   parameter int SW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  eos_mode_e         mode,
   input  logic [N_SECT-1:0] emask,
   input  logic              pbit7,
   input  logic              rd_stb,
   input  logic [SW-1:0]     rd_sect,
   input  logic [7:0]        arr_byte,
   output logic [7:0]        rd_data
);
   logic t6_q, t2_q;
   logic in_sel, prog_like, erase_like, t2_live;
   logic [7:0] nxt;

   always_comb begin
      in_sel     = emask[rd_sect];
      prog_like  = mode == M_PROG || mode == M_PPROT || mode == M_FAIL;
      erase_like = mode == M_ERASE || mode == M_EPROT || mode == M_SPEND;
      t2_live    = in_sel && (mode == M_ERASE || mode == M_SPEND || mode == M_SUSP);
      if (prog_like)
         nxt = {~pbit7, t6_q, mode == M_FAIL, 1'b0, 1'b0, t2_q, 2'b00};
      else if (erase_like)
         nxt = {1'b0, t6_q, 1'b0, 1'b0, 1'b1, t2_q, 2'b00};
      else if (mode == M_SUSP && in_sel)
         nxt = {1'b1, t6_q, 1'b0, 1'b0, 1'b1, t2_q, 2'b00};
      else
         nxt = arr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         t6_q    <= 1'b0;
         t2_q    <= 1'b0;
      end else if (rd_stb) begin
         rd_data <= nxt;
         if (prog_like || erase_like) t6_q <= ~t6_q;
         if (t2_live)                 t2_q <= ~t2_q;
      end
   end

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));
   a_r6_erase_dq7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == M_ERASE) |=> !rd_data[7]);
   a_r9_susp_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && mode == M_SUSP) |=> $stable(t6_q));
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
   import eos_pkg::*;
#(
   parameter int N_SECT  = 8,
   parameter int SECT_AW = 2,
   parameter int T_PROG  = 8,
   parameter int T_LIMIT = 40,
   parameter int T_ERASE = 64,
   parameter int T_SUSP  = 4,
   parameter int T_PPROT = 6,
   parameter int T_EPROT = 12,
   localparam int AW     = $clog2(N_SECT) + SECT_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_prog,
   input  logic              op_serase,
   input  logic              op_cerase,
   input  logic              op_suspend,
   input  logic              op_resume,
   input  logic              op_reset,
   input  logic [AW-1:0]     wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [N_SECT-1:0] sect_lock,
   input  logic              rd_stb,
   input  logic [AW-1:0]     rd_addr,
   output logic [7:0]        rd_data
);
   localparam int SW = AW - SECT_AW;

   if (N_SECT < 2 || (N_SECT & (N_SECT - 1)) != 0) begin : g_bad_sect
      $error("N_SECT must be a power of two of at least 2");
   end
   if (SECT_AW < 1 || N_SECT * (1 << SECT_AW) > 4096) begin : g_bad_size
      $error("SECT_AW out of range");
   end
   if (T_PROG < 2 || T_LIMIT <= T_PROG || T_ERASE < 2) begin : g_bad_time
      $error("program and erase durations out of range");
   end
   if (T_SUSP < 1 || T_PPROT < 1 || T_EPROT < 1) begin : g_bad_aux
      $error("auxiliary durations must be positive");
   end

   eos_mode_e         mode;
   logic [N_SECT-1:0] emask, erase_mask;
   logic              pbit7, prog_we, erase_we;
   logic [AW-1:0]     prog_addr;
   logic [7:0]        prog_data, arr_byte, cur_byte;

   eos_seq #(
      .N_SECT(N_SECT), .SECT_AW(SECT_AW), .AW(AW), .T_PROG(T_PROG),
      .T_LIMIT(T_LIMIT), .T_ERASE(T_ERASE), .T_SUSP(T_SUSP),
      .T_PPROT(T_PPROT), .T_EPROT(T_EPROT)
   ) u_seq (
      .clk, .rst_n, .op_prog, .op_serase, .op_cerase, .op_suspend,
      .op_resume, .op_reset, .wr_addr, .wr_data, .sect_lock, .cur_byte,
      .mode, .emask, .pbit7, .prog_we, .prog_addr, .prog_data,
      .erase_we, .erase_mask
   );

   eos_array #(.N_SECT(N_SECT), .SECT_AW(SECT_AW), .AW(AW)) u_arr (
      .clk, .rst_n, .prog_we, .prog_addr, .prog_data, .erase_we,
      .erase_mask, .rd_addr, .rd_byte(arr_byte), .chk_addr(wr_addr),
      .chk_byte(cur_byte)
   );

   eos_fmt #(.N_SECT(N_SECT), .SW(SW)) u_fmt (
      .clk, .rst_n, .mode, .emask, .pbit7, .rd_stb,
      .rd_sect(rd_addr[AW-1:SECT_AW]), .arr_byte, .rd_data
   );

   // R6: a completing erase always clears at least one sector
   a_r6_erase_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      erase_we |-> erase_mask != '0);
endmodule

// File: tb/tb_flash_op_status.sv
module tb_flash_op_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_prog = 0, op_serase = 0, op_cerase = 0;
   logic       op_suspend = 0, op_resume = 0, op_reset = 0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] sect_lock = '0;
   logic       rd_stb = 1'b0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [32];

   // program vectors {addr, data}; every data is a subset of what is stored
   localparam int NV = 6;
   localparam logic [12:0] VEC [NV] = '{
      {5'd0,  8'h5A}, {5'd9,  8'hA5}, {5'd0,  8'h50},
      {5'd17, 8'h3C}, {5'd31, 8'h80}, {5'd9,  8'h81}
   };

   always #5 clk = ~clk;

   flash_op_status dut (
      .clk, .rst_n, .op_prog, .op_serase, .op_cerase, .op_suspend,
      .op_resume, .op_reset, .wr_addr, .wr_data, .sect_lock, .rd_stb,
      .rd_addr, .rd_data
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp,
                      input logic [7:0] mask);
      checks++;
      if ((act & mask) !== (exp & mask)) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (mask %h)", req, act, exp, mask);
      end
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      @(negedge clk); rd_stb = 1'b1; rd_addr = a;
      @(negedge clk); rd_stb = 1'b0; v = rd_data;
   endtask

   task automatic pulse(input int which, input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d;
      case (which)
         0: op_prog = 1'b1;
         1: op_serase = 1'b1;
         2: op_cerase = 1'b1;
         3: op_suspend = 1'b1;
         4: op_resume = 1'b1;
         default: op_reset = 1'b1;
      endcase
      @(negedge clk);
      {op_prog, op_serase, op_cerase, op_suspend, op_resume, op_reset} = '0;
   endtask

   task automatic wait_done(input logic [4:0] a, input string req);
      logic [7:0] x, y;
      bit done = 1'b0;
      for (int i = 0; i < 200 && !done; i++) begin
         rd(a, x); rd(a, y);
         if (x[6] == y[6]) done = 1'b1;
      end
      chk(req, {7'b0, done}, 8'h01, 8'h01);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v, w;
      for (int i = 0; i < 32; i++) model[i] = 8'hFF;
      repeat (3) @(negedge clk);
      chk("R1 reset rd_data", rd_data, 8'h00, 8'hFF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 hold without strobe", rd_data, 8'h00, 8'hFF);
      rd(5'd3, v);
      chk("R1 erased after reset", v, 8'hFF, 8'hFF);

      // R2 R3 R4: table of programs
      for (int k = 0; k < NV; k++) begin
         logic [4:0] a;
         logic [7:0] d;
         a = VEC[k][12:8];
         d = VEC[k][7:0];
         pulse(0, a, d);
         rd(a, v); rd(a, w);
         chk("R2 R4 program status", v, {~d[7], 7'b0}, 8'hAB);
         chk("R3 dq6 toggles in program", {7'b0, v[6] ^ w[6]}, 8'h01, 8'h01);
         wait_done(a, "R3 program ends");
         model[a] = model[a] & d;
         rd(a, v);
         chk("R2 program result", v, model[a], 8'hFF);
      end

      // R5: raising a 0 fails
      pulse(0, 5'd0, 8'hFF);
      begin
         bit seen = 1'b0;
         for (int i = 0; i < 100 && !seen; i++) begin
            rd(5'd0, v);
            if (v[5]) seen = 1'b1;
         end
         chk("R5 dq5 set", {7'b0, seen}, 8'h01, 8'h01);
      end
      rd(5'd0, v); rd(5'd0, w);
      chk("R5 dq5 sticky", v, 8'h20, 8'h20);
      chk("R5 dq6 still toggles", {7'b0, v[6] ^ w[6]}, 8'h01, 8'h01);
      pulse(5, 5'd0, 8'h00);
      rd(5'd0, v);
      chk("R5 data unchanged after reset", v, model[0], 8'hFF);

      // R13: reset during program ignored
      pulse(0, 5'd17, 8'h14);
      pulse(5, 5'd17, 8'h00);
      rd(5'd17, v);
      chk("R13 reset ignored in program", v, 8'h80, 8'hA8);
      wait_done(5'd17, "R13 program ends");
      model[17] = model[17] & 8'h14;
      rd(5'd17, v);
      chk("R13 program result", v, model[17], 8'hFF);

      // R6 R8: sector erase of sector 2
      pulse(1, 5'd9, 8'h00);
      pulse(0, 5'd0, 8'h00); // R13 start ignored during erase
      rd(5'd9, v); rd(5'd9, w);
      chk("R6 R4 erase status", v, 8'h08, 8'hAB);
      chk("R8 dq2 toggles in sector", {7'b0, v[2] ^ w[2]}, 8'h01, 8'h01);
      rd(5'd0, v); rd(5'd0, w);
      chk("R8 dq2 steady elsewhere", {7'b0, v[2] ^ w[2]}, 8'h00, 8'h01);
      wait_done(5'd9, "R6 erase ends");
      rd(5'd9, v);
      chk("R6 sector erased", v, 8'hFF, 8'hFF);
      rd(5'd17, v);
      chk("R6 other sector kept", v, model[17], 8'hFF);
      rd(5'd0, v);
      chk("R13 start ignored in erase", v, model[0], 8'hFF);
      model[9] = 8'hFF;

      // R9 R10 R11: suspend sector 4
      pulse(1, 5'd17, 8'h00);
      pulse(3, 5'd0, 8'h00);
      repeat (6) @(negedge clk);
      rd(5'd17, v); rd(5'd17, w);
      chk("R9 suspended status", v, 8'h88, 8'hA8);
      chk("R9 dq6 steady", {7'b0, v[6] ^ w[6]}, 8'h00, 8'h01);
      chk("R9 dq2 toggles", {7'b0, v[2] ^ w[2]}, 8'h01, 8'h01);
      rd(5'd31, v);
      chk("R9 other sector data", v, model[31], 8'hFF);
      pulse(0, 5'd30, 8'h12);
      rd(5'd30, v);
      chk("R10 suspend program status", v, 8'h80, 8'hA8);
      wait_done(5'd30, "R10 program ends");
      model[30] = 8'h12;
      rd(5'd30, v);
      chk("R10 program result", v, 8'h12, 8'hFF);
      rd(5'd17, v);
      chk("R10 back to suspend", v, 8'h88, 8'hA8);
      pulse(0, 5'd16, 8'h00);
      rd(5'd31, v);
      chk("R10 program to suspended sector ignored", v, model[31], 8'hFF);
      pulse(4, 5'd0, 8'h00);
      rd(5'd17, v);
      chk("R11 erasing again", v, 8'h08, 8'h88);
      wait_done(5'd17, "R11 erase ends");
      rd(5'd17, v);
      chk("R11 sector erased", v, 8'hFF, 8'hFF);
      rd(5'd16, v);
      chk("R11 suspended program dropped", v, 8'hFF, 8'hFF);
      model[17] = 8'hFF;

      // R7 R9: chip erase, sector 7 protected, suspend ignored
      sect_lock = 8'h80;
      pulse(2, 5'd0, 8'h00);
      pulse(3, 5'd0, 8'h00);
      repeat (8) @(negedge clk);
      rd(5'd12, v);
      chk("R9 suspend ignored in chip erase", v, 8'h08, 8'h88);
      wait_done(5'd12, "R7 chip erase ends");
      rd(5'd0, v);
      chk("R7 unprotected erased", v, 8'hFF, 8'hFF);
      rd(5'd30, v);
      chk("R7 protected kept", v, 8'h12, 8'hFF);

      // R12: protected program and erase
      pulse(0, 5'd31, 8'h00);
      rd(5'd31, v); rd(5'd31, w);
      chk("R12 protected program toggles", {7'b0, v[6] ^ w[6]}, 8'h01, 8'h01);
      wait_done(5'd31, "R12 protected program ends");
      rd(5'd31, v);
      chk("R12 protected program no change", v, 8'h80, 8'hFF);
      pulse(1, 5'd28, 8'h00);
      rd(5'd30, v);
      chk("R12 protected erase status", v, 8'h08, 8'h88);
      wait_done(5'd30, "R12 protected erase ends");
      rd(5'd30, v);
      chk("R12 protected erase no change", v, 8'h12, 8'hFF);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule